// File: doc/BRIEF.md
# Receive FIFO Pause Flow Controller

This block watches how full a receive FIFO is and decides when the link partner should be asked to stop sending. In full duplex it asks the transmit side to send an IEEE 802.3x pause frame. In half duplex it applies carrier backpressure for a set time instead. The high and low marks are given in 64-byte units. The block compares them with a FIFO level counted in bytes. The marks form a hysteresis band: a pause is requested once on the way up, and a zero-time pause (resume) is requested once on the way back down.

The controller is a six-state machine:

- `FC_WAIT_LOW` is entered at reset and after every resume. It moves to `FC_ARMED` once the level is strictly below the low mark.
- From `FC_ARMED`, when the level rises strictly above the high mark with triggering enabled:
  - in full duplex it moves to `FC_XOFF_REQ`;
  - in half duplex it moves to `FC_BACKOFF` and starts the backpressure timer.
- `FC_XOFF_REQ` holds a request carrying the configured pause time. An acknowledge moves it to `FC_PAUSED`.
- `FC_PAUSED` moves to `FC_XON_REQ` when the level falls to or below the low mark.
- `FC_XON_REQ` holds a zero-time request. An acknowledge moves it back to `FC_WAIT_LOW`.
- `FC_BACKOFF` returns to `FC_WAIT_LOW` when the level falls to or below the low mark. Each fresh upward crossing of the high mark while in `FC_BACKOFF` restarts the timer.

The timer counts microseconds from a prescaled tick. The duration is `(code+1) * BP_STEP_US` microseconds.

Top module: `rx_pause_flowctl`

## Requirements
- R1: After reset `pause_req` and `bp_assert` are 0. `pause_quanta` is 0 whenever `pause_req` is 0. No request is made until the level has first been strictly below `lo_mark*64`.
- R2: The level triggers only when strictly greater than `hi_mark*64`. A level equal to `hi_mark*64` does not trigger.
- R3: In full duplex, an armed block whose level exceeds the high mark raises `pause_req` one cycle later, with `pause_quanta` equal to `pause_time` as sampled at the trigger.
- R4: `pause_req` and `pause_quanta` hold unchanged until `pause_ack` is 1 in a cycle where `pause_req` is 1. `pause_req` is 0 in the following cycle. Changes to `pause_time` meanwhile have no effect.
- R5: After an acknowledged pause, no new non-zero request is made while the level stays above the low mark. When the level is at or below `lo_mark*64`, one request with `pause_quanta` = 0 is raised.
- R6: After the zero-time request, a new pause requires the level to go strictly below `lo_mark*64` and then above `hi_mark*64`. A level exactly one byte above the low mark does not re-arm.
- R7: In half duplex the trigger raises `bp_assert` one cycle later, for exactly `(bp_code+1)*BP_STEP_US*US_CYCLES` cycles, and no pause request is made.
- R8: While in backoff, a new upward crossing of the high mark restarts the full duration. A level that merely stays above the high mark does not.
- R9: With `trig_en` = 0 neither `pause_req` nor `bp_assert` is raised. Setting `trig_en` while the level is above the high mark triggers on the next edge.
- R10: `pause_ack` while no request is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | LEVEL_W | Receive FIFO fill level in bytes |
| hi_mark | input | MARK_W | Upper threshold, 64-byte units |
| lo_mark | input | MARK_W | Lower threshold, 64-byte units |
| trig_en | input | 1 | Enables pause or backpressure triggering |
| bp_code | input | CODE_W | Backpressure duration selector |
| pause_time | input | QUANTA_W | Pause time, 512-bit-time units |
| full_duplex | input | 1 | 1 = pause frames, 0 = backpressure |
| pause_ack | input | 1 | One-cycle acknowledge from transmit side |
| pause_req | output | 1 | Pause frame request |
| pause_quanta | output | QUANTA_W | Pause time carried by the request |
| bp_assert | output | 1 | Apply carrier backpressure |

## Verification
Directed cases walk the level across both marks, including the values exactly on each mark and one byte past them. This separates strict from inclusive comparisons and shows whether re-arming is genuine. Random phases drive full-duplex level walks chosen from five classes: below low, on low, between, on high and above high. They use random thresholds, random acknowledge timing and stray acknowledges, and are compared cycle by cycle against a bench model of the hysteresis band. Half-duplex cases count the exact backpressure length for two duration codes, and check a restart mid-run against a level that merely stays high.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    typedef enum logic [2:0] {
        FC_WAIT_LOW = 3'd0,
        FC_ARMED    = 3'd1,
        FC_XOFF_REQ = 3'd2,
        FC_PAUSED   = 3'd3,
        FC_XON_REQ  = 3'd4,
        FC_BACKOFF  = 3'd5
    } fc_state_e;

endpackage

// File: rtl/rxfc_level_cmp.sv
module rxfc_level_cmp #(
    parameter int LEVEL_W    = 16,
    parameter int MARK_W     = 8,
    parameter int UNIT_SHIFT = 6
) (
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic [MARK_W-1:0]  hi_mark,
    input  logic [MARK_W-1:0]  lo_mark,
    output logic               above_hi,
    output logic               below_lo,
    output logic               at_or_below_lo
);
    localparam int THR_W = MARK_W + UNIT_SHIFT;
    localparam int CMP_W = ((LEVEL_W > THR_W) ? LEVEL_W : THR_W) + 1;

    logic [CMP_W-1:0] lvl_x;
    logic [CMP_W-1:0] hi_x;
    logic [CMP_W-1:0] lo_x;

    generate
        if (UNIT_SHIFT == 0) begin : g_bytes
            assign hi_x = CMP_W'(hi_mark);
            assign lo_x = CMP_W'(lo_mark);
        end else begin : g_units
            assign hi_x = CMP_W'({hi_mark, {UNIT_SHIFT{1'b0}}});
            assign lo_x = CMP_W'({lo_mark, {UNIT_SHIFT{1'b0}}});
        end
    endgenerate

    assign lvl_x          = CMP_W'(fifo_level);
    assign above_hi       = (lvl_x > hi_x);
    assign below_lo       = (lvl_x < lo_x);
    assign at_or_below_lo = (lvl_x <= lo_x);

endmodule

// File: rtl/rxfc_fsm.sv
module rxfc_fsm
    import rxfc_pkg::*;
#(
    parameter int QUANTA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                above_hi,
    input  logic                below_lo,
    input  logic                at_or_below_lo,
    input  logic                trig_en,
    input  logic                full_duplex,
    input  logic                pause_ack,
    input  logic [QUANTA_W-1:0] pause_time,
    output logic                pause_req,
    output logic [QUANTA_W-1:0] pause_quanta,
    output logic                bp_start
);
    fc_state_e            state;
    fc_state_e            nxt;
    logic                 above_hi_q;
    logic [QUANTA_W-1:0]  quanta_q;
    logic                 trigger;

    assign trigger = above_hi && trig_en;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            FC_WAIT_LOW: if (below_lo)       nxt = FC_ARMED;
            FC_ARMED:    if (trigger)        nxt = full_duplex ? FC_XOFF_REQ : FC_BACKOFF;
            FC_XOFF_REQ: if (pause_ack)      nxt = FC_PAUSED;
            FC_PAUSED:   if (at_or_below_lo) nxt = FC_XON_REQ;
            FC_XON_REQ:  if (pause_ack)      nxt = FC_WAIT_LOW;
            FC_BACKOFF:  if (at_or_below_lo) nxt = FC_WAIT_LOW;
            default:                         nxt = FC_WAIT_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FC_WAIT_LOW;
        end else begin
            state <= nxt;
        end
    end

    // edge memory and captured pause time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            above_hi_q <= 1'b0;
            quanta_q   <= '0;
        end else begin
            above_hi_q <= above_hi;
            if (state == FC_ARMED && trigger && full_duplex) begin
                quanta_q <= pause_time;
            end
        end
    end

    // outputs
    always_comb begin
        pause_req    = 1'b0;
        pause_quanta = '0;
        bp_start     = 1'b0;
        unique case (state)
            FC_XOFF_REQ: begin
                pause_req    = 1'b1;
                pause_quanta = quanta_q;
            end
            FC_XON_REQ: begin
                pause_req    = 1'b1;
            end
            FC_ARMED: begin
                bp_start = trigger && !full_duplex;
            end
            FC_BACKOFF: begin
                bp_start = trigger && !above_hi_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rxfc_bp_timer.sv
module rxfc_bp_timer #(
    parameter int CODE_W     = 4,
    parameter int US_CYCLES  = 100,
    parameter int BP_STEP_US = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] bp_code,
    output logic              active
);
    localparam int US_MAX = (1 << CODE_W) * BP_STEP_US;
    localparam int US_W   = $clog2(US_MAX + 1);

    logic [US_W-1:0] us_left;
    logic [US_W-1:0] us_load;
    logic            us_tick;

    assign us_load = US_W'((32'(bp_code) + 32'd1) * 32'(BP_STEP_US));

    generate
        if (US_CYCLES <= 1) begin : g_no_pre
            assign us_tick = active;
        end else begin : g_pre
            localparam int PRE_W = $clog2(US_CYCLES);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(US_CYCLES - 1);
            logic [PRE_W-1:0] pre;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre <= '0;
                end else if (start) begin
                    pre <= PRE_LAST;
                end else if (active) begin
                    pre <= (pre == '0) ? PRE_LAST : pre - 1'b1;
                end
            end
            assign us_tick = active && (pre == '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            us_left <= '0;
        end else if (start) begin
            active  <= 1'b1;
            us_left <= us_load;
        end else if (us_tick) begin
            if (us_left == US_W'(1)) begin
                active <= 1'b0;
            end
            us_left <= us_left - 1'b1;
        end
    end

endmodule

// File: rtl/rx_pause_flowctl.sv
module rx_pause_flowctl #(
    parameter int LEVEL_W    = 16,
    parameter int MARK_W     = 8,
    parameter int UNIT_SHIFT = 6,
    parameter int QUANTA_W   = 16,
    parameter int CODE_W     = 4,
    parameter int US_CYCLES  = 100,
    parameter int BP_STEP_US = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LEVEL_W-1:0]  fifo_level,
    input  logic [MARK_W-1:0]   hi_mark,
    input  logic [MARK_W-1:0]   lo_mark,
    input  logic                trig_en,
    input  logic [CODE_W-1:0]   bp_code,
    input  logic [QUANTA_W-1:0] pause_time,
    input  logic                full_duplex,
    input  logic                pause_ack,
    output logic                pause_req,
    output logic [QUANTA_W-1:0] pause_quanta,
    output logic                bp_assert
);
    logic above_hi;
    logic below_lo;
    logic at_or_below_lo;
    logic bp_start;

    rxfc_level_cmp #(
        .LEVEL_W   (LEVEL_W),
        .MARK_W    (MARK_W),
        .UNIT_SHIFT(UNIT_SHIFT)
    ) u_cmp (
        .fifo_level    (fifo_level),
        .hi_mark       (hi_mark),
        .lo_mark       (lo_mark),
        .above_hi      (above_hi),
        .below_lo      (below_lo),
        .at_or_below_lo(at_or_below_lo)
    );

    rxfc_fsm #(
        .QUANTA_W(QUANTA_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .above_hi      (above_hi),
        .below_lo      (below_lo),
        .at_or_below_lo(at_or_below_lo),
        .trig_en       (trig_en),
        .full_duplex   (full_duplex),
        .pause_ack     (pause_ack),
        .pause_time    (pause_time),
        .pause_req     (pause_req),
        .pause_quanta  (pause_quanta),
        .bp_start      (bp_start)
    );

    rxfc_bp_timer #(
        .CODE_W    (CODE_W),
        .US_CYCLES (US_CYCLES),
        .BP_STEP_US(BP_STEP_US)
    ) u_bp (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (bp_start),
        .bp_code(bp_code),
        .active (bp_assert)
    );

endmodule

// File: rtl/rxfc_chk.sv
module rxfc_chk #(
    parameter int QUANTA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                full_duplex,
    input logic                trig_en,
    input logic                pause_ack,
    input logic                pause_req,
    input logic [QUANTA_W-1:0] pause_quanta,
    input logic                bp_assert
);
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && !pause_ack |=> pause_req);

    // R4
    quanta_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && !pause_ack |=> $stable(pause_quanta));

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && pause_ack |=> !pause_req);

    // R7
    hd_no_xoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_req) && (pause_quanta != '0) |-> $past(full_duplex));

    // R9
    bp_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bp_assert) |-> $past(trig_en));

    // R1
    idle_quanta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_req |-> (pause_quanta == '0));

endmodule

bind rx_pause_flowctl rxfc_chk #(.QUANTA_W(QUANTA_W)) i_rxfc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_duplex (full_duplex),
    .trig_en     (trig_en),
    .pause_ack   (pause_ack),
    .pause_req   (pause_req),
    .pause_quanta(pause_quanta),
    .bp_assert   (bp_assert)
);

// File: tb/test_rx_pause_flowctl.sv
module test_rx_pause_flowctl;
    localparam int US_CYC = 4;
    localparam int STEP   = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] fifo_level;
    logic [7:0]  hi_mark, lo_mark;
    logic        trig_en;
    logic [3:0]  bp_code;
    logic [15:0] pause_time;
    logic        full_duplex;
    logic        pause_ack;
    logic        pause_req;
    logic [15:0] pause_quanta;
    logic        bp_assert;

    int n_run  = 0;
    int n_fail = 0;

    int        m_st;
    logic [15:0] m_q;

    always #5 clk = ~clk;

    rx_pause_flowctl #(.US_CYCLES(US_CYC), .BP_STEP_US(STEP)) i_rx_pause_flowctl (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .hi_mark(hi_mark),
        .lo_mark(lo_mark), .trig_en(trig_en), .bp_code(bp_code),
        .pause_time(pause_time), .full_duplex(full_duplex), .pause_ack(pause_ack),
        .pause_req(pause_req), .pause_quanta(pause_quanta), .bp_assert(bp_assert)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ack_once();
        pause_ack = 1'b1;
        step();
        pause_ack = 1'b0;
    endtask

    // counts consecutive samples with backpressure high, flags any pause request
    task automatic measure_bp(output int cnt, output int saw_req);
        cnt = 0;
        saw_req = 0;
        while (bp_assert && cnt < 2000) begin
            cnt++;
            if (pause_req) saw_req = 1;
            step();
        end
    endtask

    function automatic int exp_bp_len(input int code);
        return (code + 1) * STEP * US_CYC;
    endfunction

    // bench model of the hysteresis band, full duplex
    task automatic model_step(input int lvl, input logic ack);
        bit ah, bl, al;
        ah = lvl > int'(hi_mark) * 64;
        bl = lvl < int'(lo_mark) * 64;
        al = lvl <= int'(lo_mark) * 64;
        case (m_st)
            0: if (bl) m_st = 1;
            1: if (ah && trig_en) begin
                   if (full_duplex) begin m_st = 2; m_q = pause_time; end
                   else m_st = 5;
               end
            2: if (ack) m_st = 3;
            3: if (al) m_st = 4;
            4: if (ack) m_st = 0;
            5: if (al) m_st = 0;
            default: m_st = 0;
        endcase
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pause_ack = 1'b0;
        step(); step(); step();
        rst_n = 1'b1;
        m_st = 0;
        m_q = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cnt, sreq;
        void'($urandom(32'h5eed_1234));
        fifo_level = 16'd600; hi_mark = 8'd8; lo_mark = 8'd4; trig_en = 1'b1;
        bp_code = 4'd3; pause_time = 16'h1234; full_duplex = 1'b1; pause_ack = 1'b0;
        rst_n = 1'b0;
        step();
        chk("R1 reset req", pause_req, 0);
        chk("R1 reset bp", bp_assert, 0);
        chk("R1 reset quanta", pause_quanta, 0);
        rst_n = 1'b1;
        step(); step(); step();
        chk("R1 not armed above high", pause_req, 0);

        fifo_level = 16'd255; step();
        fifo_level = 16'd512; step(); step();
        chk("R2 equal high no trigger", pause_req, 0);
        fifo_level = 16'd513; step();
        chk("R2 R3 trigger req", pause_req, 1);
        chk("R3 quanta", pause_quanta, 16'h1234);
        pause_time = 16'h5555; step(); step();
        chk("R4 held req", pause_req, 1);
        chk("R4 quanta stable", pause_quanta, 16'h1234);
        ack_once();
        chk("R4 drop after ack", pause_req, 0);

        fifo_level = 16'd300; step();
        fifo_level = 16'd700; step();
        chk("R5 no second pause", pause_req, 0);
        fifo_level = 16'd256; step();
        chk("R5 resume req", pause_req, 1);
        chk("R5 resume quanta", pause_quanta, 0);
        ack_once();
        chk("R5 resume drop", pause_req, 0);

        fifo_level = 16'd257; step();
        fifo_level = 16'd700; step(); step();
        chk("R6 no rearm at low+1", pause_req, 0);
        fifo_level = 16'd100; step();
        fifo_level = 16'd700; step();
        chk("R6 rearmed req", pause_req, 1);
        chk("R6 new quanta", pause_quanta, 16'h5555);
        ack_once();
        fifo_level = 16'd100; step();
        chk("R5 second resume", pause_req, 1);
        ack_once();
        step();

        trig_en = 1'b0; fifo_level = 16'd700;
        repeat (4) step();
        chk("R9 disabled no req", pause_req, 0);
        chk("R9 disabled no bp", bp_assert, 0);
        ack_once(); step();
        chk("R10 stray ack", pause_req, 0);
        trig_en = 1'b1; step();
        chk("R9 enable triggers", pause_req, 1);
        chk("R10 quanta after stray ack", pause_quanta, 16'h5555);
        ack_once();
        fifo_level = 16'd100; step();
        ack_once();
        step();

        full_duplex = 1'b0; fifo_level = 16'd700; step();
        measure_bp(cnt, sreq);
        chk("R7 bp length code3", cnt, exp_bp_len(3));
        chk("R7 no pause in half duplex", sreq, 0);
        step(); step(); step();
        chk("R8 no restart while staying high", bp_assert, 0);

        fifo_level = 16'd100; step(); step();
        fifo_level = 16'd700; step();
        repeat (9) step();
        chk("R8 running before restart", bp_assert, 1);
        fifo_level = 16'd300; step();
        fifo_level = 16'd700; step();
        measure_bp(cnt, sreq);
        chk("R8 restart length", cnt, exp_bp_len(3));

        fifo_level = 16'd100; step(); step();
        bp_code = 4'd0; fifo_level = 16'd700; step();
        measure_bp(cnt, sreq);
        chk("R7 bp length code0", cnt, exp_bp_len(0));

        full_duplex = 1'b1;
        for (int blk = 0; blk < 3; blk++) begin
            int lo, hi;
            lo = 1 + int'($urandom % 100);
            hi = lo + 1 + int'($urandom % 100);
            lo_mark = 8'(lo); hi_mark = 8'(hi);
            pause_time = 16'($urandom);
            trig_en = 1'b1;
            fifo_level = 16'd0;
            do_reset();
            for (int i = 0; i < 1500; i++) begin
                int cls, lvl;
                logic ak;
                cls = int'($urandom % 6);
                case (cls)
                    0: lvl = int'($urandom % (lo * 64));
                    1: lvl = lo * 64;
                    2: lvl = lo * 64 + 1 + int'($urandom % (hi * 64 - lo * 64 - 1));
                    3: lvl = hi * 64;
                    default: lvl = hi * 64 + 1 + int'($urandom % (16383 - hi * 64));
                endcase
                if (m_st == 2 || m_st == 4) ak = ($urandom % 2) == 0;
                else ak = ($urandom % 8) == 0;
                fifo_level = 16'(lvl);
                pause_ack = ak;
                trig_en = ($urandom % 10) != 0;
                if (($urandom % 50) == 0) pause_time = 16'($urandom);
                model_step(lvl, ak);
                step();
                chk("R3 R5 R6 R10 random req", pause_req, (m_st == 2 || m_st == 4) ? 1 : 0);
                chk("R4 random quanta", pause_quanta, (m_st == 2) ? m_q : 16'd0);
            end
            pause_ack = 1'b0;
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule